// File: doc/BRIEF.md
# Polyphase Window Scanner

This block sits in front of a bank of 2-D filter units. It takes a raster-ordered stream of square frames, one sample per handshake. For every output position (m, n) of a half-resolution grid, it collects the L x M neighbourhood that ends at input sample (2m, 2n). It then hands that neighbourhood to the filters as four parity-separated subwindows of L/2 x M/2 samples each. Because a window is produced only at positions where both the row and the column are even, decimation by two is a side effect of the scan and needs no separate stage.

Storage is kept to a few rows. Rows are steered by parity into two line banks: the even bank holds L/2-1 rows and the odd bank holds L/2 rows. A short column-history shift register supplies the M-1 previous columns of the current window. A fixed parity demultiplexer wires each stored sample to its subwindow slot. Samples at negative row or column indices read as zero.

Both the input and the output are valid/ready streams. A sample transfers when `in_valid` and `in_ready` are both high on a rising edge. A window transfers when `win_valid` and `win_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While a window waits with `win_ready` low, `in_ready` is low and the window ports hold still, so back-pressure from the filters stops the scan without losing data.

Top module: `pw_scanner`

## Requirements
- R1: After reset `win_valid` is low and `in_ready` is high.
- R2: Accepting input sample (2m, 2n) loads the window for output position (m, n), and `win_valid` is high on the next cycle. A full N x N frame yields exactly (N/2)^2 windows, in raster order of (m, n).
- R3: Element index e = a*(M/2)+b occupies bits [e*W +: W] of each subwindow port. In `win_ee` that element is S(2m-2a, 2n-2b). In `win_oe` (odd row offset) it is S(2m-1-2a, 2n-2b).
- R4: In `win_eo` element e holds S(2m-2a, 2n-1-2b). In `win_oo` it holds S(2m-1-2a, 2n-1-2b).
- R5: Any referenced sample with a negative row or column index reads as zero.
- R6: A sample accepted with `in_sof` high is taken as position (0,0) of a new frame. No row from before it contributes to any later window.
- R7: The first sample accepted after the last sample (N-1, N-1) of a frame starts a new frame at (0,0), with earlier rows discarded, even when `in_sof` is low.
- R8: While `win_valid` is high and `win_ready` is low, `in_ready` is low and all four subwindow ports and `win_valid` hold their values.
- R9: Cycles with `in_valid` low change no state, so idle gaps in the input leave every window unchanged.
- R10: A window transferred in a cycle in which no new window is loaded leaves `win_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take an input sample |
| in_sof | input | 1 | Qualifies the current sample as frame position (0,0) |
| in_data | input | W | Input sample |
| win_valid | output | 1 | A window is presented |
| win_ready | input | 1 | Consumer takes the window |
| win_ee | output | (L/2)*(M/2)*W | Even-row, even-column subwindow |
| win_oe | output | (L/2)*(M/2)*W | Odd-row, even-column subwindow |
| win_eo | output | (L/2)*(M/2)*W | Even-row, odd-column subwindow |
| win_oo | output | (L/2)*(M/2)*W | Odd-row, odd-column subwindow |

## Verification
A position counter that drifts, or a bank write that goes to the wrong parity, shows up at the ports within the next window or two. The damage appears as a subwindow slot that holds a neighbour's sample, or as a window that is missing or extra in the per-frame count. A line bank that is not cleared on a restart stays hidden until the first window of the next frame, where the top rows should read as zero but do not. The bench therefore uses a constant all-ones frame just before restart and wrap frames.

// File: rtl/pws_pkg.sv
package pws_pkg;
  // Phase index: bit 0 = row parity offset, bit 1 = column parity offset
  localparam int PH_EE  = 0;
  localparam int PH_OE  = 1;
  localparam int PH_EO  = 2;
  localparam int PH_OO  = 3;
  localparam int NUM_PH = 4;

  function automatic int row_par(input int ph);
    return ph & 1;
  endfunction

  function automatic int col_par(input int ph);
    return (ph >> 1) & 1;
  endfunction
endpackage

// File: rtl/pws_scan_ctrl.sv
module pws_scan_ctrl #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 sof,
  output logic [$clog2(N)-1:0] pos_row,
  output logic [$clog2(N)-1:0] pos_col,
  output logic                 frame_start,
  output logic                 even_pos
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] row_q, col_q;

  // A flagged sample is position (0,0) whatever the counters hold
  assign pos_row     = sof ? '0 : row_q;
  assign pos_col     = sof ? '0 : col_q;
  assign frame_start = sof || (row_q == '0 && col_q == '0);
  assign even_pos    = ~pos_row[0] & ~pos_col[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      if (pos_col == LAST) begin
        col_q <= '0;
        row_q <= (pos_row == LAST) ? '0 : pos_row + 1'b1;
      end else begin
        col_q <= pos_col + 1'b1;
        row_q <= pos_row;
      end
    end
  end
endmodule

// File: rtl/pws_row_bank.sv
module pws_row_bank #(
  parameter int W     = 8,
  parameter int N     = 8,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [$clog2(N)-1:0]       col,
  input  logic [W-1:0]               din,
  output logic [DEPTH-1:0][W-1:0]    rd
);
  // mem[0] is the newest row of this parity, mem[DEPTH-1] the oldest
  logic [W-1:0] mem [DEPTH][N];

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int d = 0; d < DEPTH; d++)
        for (int c = 0; c < N; c++)
          mem[d][c] <= '0;
    end
    if (wr_en) begin
      mem[0][col] <= din;
      for (int d = 1; d < DEPTH; d++)
        mem[d][col] <= clear ? '0 : mem[d-1][col];
    end
  end

  // On a frame start the stored rows belong to the old frame: read zero
  always_comb begin
    for (int d = 0; d < DEPTH; d++)
      rd[d] = clear ? '0 : mem[d][col];
  end
endmodule

// File: rtl/pws_col_hist.sv
module pws_col_hist #(
  parameter int W = 8,
  parameter int L = 4,
  parameter int M = 4
) (
  input  logic                              clk,
  input  logic                              shift,
  input  logic [L-1:0][W-1:0]               vec,
  output logic [M-2:0][L-1:0][W-1:0]        taps
);
  // taps[j] holds the column vector of column c-1-j
  always_ff @(posedge clk) begin
    if (shift) begin
      taps[0] <= vec;
      for (int j = 1; j < M - 1; j++)
        taps[j] <= taps[j-1];
    end
  end
endmodule

// File: rtl/pws_demux.sv
module pws_demux
  import pws_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 8,
  parameter int L = 4,
  parameter int M = 4
) (
  input  logic [L-1:0][W-1:0]                            cur,
  input  logic [M-2:0][L-1:0][W-1:0]                     taps,
  input  logic [$clog2(N)-1:0]                           col,
  output logic [NUM_PH-1:0][(L/2)*(M/2)-1:0][W-1:0]      sub
);
  localparam int HL = L / 2;
  localparam int HM = M / 2;

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_ph
    for (genvar a = 0; a < HL; a++) begin : g_row
      for (genvar b = 0; b < HM; b++) begin : g_col
        localparam int K = 2 * a + row_par(ph);
        localparam int D = 2 * b + col_par(ph);
        logic [W-1:0] raw;
        if (D == 0) begin : g_now
          assign raw = cur[K];
        end else begin : g_old
          assign raw = taps[D-1][K];
        end
        // Columns left of the frame edge read as zero
        assign sub[ph][a*HM+b] = (int'(col) >= D) ? raw : '0;
      end
    end
  end
endmodule

// File: rtl/pw_scanner.sv
module pw_scanner
  import pws_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 8,
  parameter int L = 4,
  parameter int M = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_sof,
  input  logic [W-1:0]                 in_data,
  output logic                         win_valid,
  input  logic                         win_ready,
  output logic [(L/2)*(M/2)*W-1:0]     win_ee,
  output logic [(L/2)*(M/2)*W-1:0]     win_oe,
  output logic [(L/2)*(M/2)*W-1:0]     win_eo,
  output logic [(L/2)*(M/2)*W-1:0]     win_oo
);
  localparam int CW    = $clog2(N);
  localparam int HL    = L / 2;
  localparam int HM    = M / 2;
  localparam int SUBN  = HL * HM;
  localparam int EVN_D = HL - 1;   // even rows older than the current one
  localparam int ODD_D = HL;       // odd rows above the current even row

  logic           accept, frame_start, even_pos, clear, fire;
  logic [CW-1:0]  pos_row, pos_col;
  logic           win_valid_q;

  logic [EVN_D-1:0][W-1:0]                evn_rd;
  logic [ODD_D-1:0][W-1:0]                odd_rd;
  logic [L-1:0][W-1:0]                    vec;
  logic [M-2:0][L-1:0][W-1:0]             taps;
  logic [NUM_PH-1:0][SUBN-1:0][W-1:0]     sub_d, sub_q;

  assign in_ready = !win_valid_q || win_ready;
  assign accept   = in_valid && in_ready;
  assign clear    = accept && frame_start;
  assign fire     = accept && even_pos;

  pws_scan_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof),
    .pos_row(pos_row), .pos_col(pos_col),
    .frame_start(frame_start), .even_pos(even_pos)
  );

  pws_row_bank #(.W(W), .N(N), .DEPTH(EVN_D)) u_even_bank (
    .clk(clk), .clear(clear), .wr_en(accept && !pos_row[0]),
    .col(pos_col), .din(in_data), .rd(evn_rd)
  );

  pws_row_bank #(.W(W), .N(N), .DEPTH(ODD_D)) u_odd_bank (
    .clk(clk), .clear(clear), .wr_en(accept && pos_row[0]),
    .col(pos_col), .din(in_data), .rd(odd_rd)
  );

  // Column vector at the current column: rows r, r-1, ..., r-L+1
  for (genvar k = 0; k < L; k++) begin : g_vec
    if (k == 0) begin : g_cur
      assign vec[k] = in_data;
    end else if (k % 2 == 1) begin : g_odd
      assign vec[k] = odd_rd[(k-1)/2];
    end else begin : g_even
      assign vec[k] = evn_rd[k/2-1];
    end
  end

  pws_col_hist #(.W(W), .L(L), .M(M)) u_hist (
    .clk(clk), .shift(accept), .vec(vec), .taps(taps)
  );

  pws_demux #(.W(W), .N(N), .L(L), .M(M)) u_demux (
    .cur(vec), .taps(taps), .col(pos_col), .sub(sub_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_q <= 1'b0;
      sub_q       <= '0;
    end else if (fire) begin
      win_valid_q <= 1'b1;
      sub_q       <= sub_d;
    end else if (win_ready) begin
      win_valid_q <= 1'b0;
    end
  end

  assign win_valid = win_valid_q;
  assign win_ee    = sub_q[PH_EE];
  assign win_oe    = sub_q[PH_OE];
  assign win_eo    = sub_q[PH_EO];
  assign win_oo    = sub_q[PH_OO];
endmodule

// File: rtl/pw_scanner_chk.sv
module pw_scanner_chk #(
  parameter int W = 8,
  parameter int N = 8,
  parameter int L = 4,
  parameter int M = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       in_sof,
  input logic                       win_valid,
  input logic                       win_ready,
  input logic [(L/2)*(M/2)*W-1:0]   win_ee,
  input logic [(L/2)*(M/2)*W-1:0]   win_oe,
  input logic [(L/2)*(M/2)*W-1:0]   win_eo,
  input logic [(L/2)*(M/2)*W-1:0]   win_oo
);
  localparam int CW = $clog2(N);

  // Independent position tracker seen from the ports
  logic [CW-1:0] k_row, k_col, e_row, e_col;
  logic          acc, acc_ee;

  assign acc    = in_valid && in_ready;
  assign e_row  = in_sof ? '0 : k_row;
  assign e_col  = in_sof ? '0 : k_col;
  assign acc_ee = acc && !e_row[0] && !e_col[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_row <= '0;
      k_col <= '0;
    end else if (acc) begin
      if (int'(e_col) == N - 1) begin
        k_col <= '0;
        k_row <= (int'(e_row) == N - 1) ? '0 : e_row + 1'b1;
      end else begin
        k_col <= e_col + 1'b1;
        k_row <= e_row;
      end
    end
  end

  a_r1_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> in_ready);

  a_r2_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ee |=> win_valid);

  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ready) |-> !in_ready);

  a_r8_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ready) |=>
      (win_valid && $stable(win_ee) && $stable(win_oe) && $stable(win_eo) && $stable(win_oo)));

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && !acc_ee) |=> !win_valid);
endmodule

bind pw_scanner pw_scanner_chk #(.W(W), .N(N), .L(L), .M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .win_valid(win_valid), .win_ready(win_ready),
  .win_ee(win_ee), .win_oe(win_oe), .win_eo(win_eo), .win_oo(win_oo)
);

// File: tb/sim_pw_scanner.sv
module sim_pw_scanner;
  localparam int W          = 8;
  localparam int N          = 8;
  localparam int L          = 4;
  localparam int M          = 4;
  localparam int HL         = L / 2;
  localparam int HM         = M / 2;
  localparam int SUBN       = HL * HM;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, win_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, win_valid;
  logic [SUBN*W-1:0] win_ee, win_oe, win_eo, win_oo;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_scanner #(.W(W), .N(N), .L(L), .M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .win_valid(win_valid),
    .win_ready(win_ready), .win_ee(win_ee), .win_oe(win_oe),
    .win_eo(win_eo), .win_oo(win_oo)
  );

  int checks = 0;
  int errors = 0;
  int q_pat [512];
  int q_m   [512];
  int q_n   [512];
  int qh = 0, qt = 0;
  int seen = 0;
  bit done = 0;
  logic [7:0] lf = 8'h5a;

  function automatic int pix(int pat, int r, int c);
    if (r < 0 || c < 0) return 0;
    case (pat)
      0:       return (r * N + c + 1) & 255;
      1:       return (r * 37 + c * 11 + 5) & 255;
      2:       return 255;
      default: return (200 - r * 16 - c * 3) & 255;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SUBN*W-1:0] bus_of(int ph);
    case (ph)
      0:       return win_ee;
      1:       return win_oe;
      2:       return win_eo;
      default: return win_oo;
    endcase
  endfunction

  task automatic check_window();
    if (qh == qt) begin
      chk(0, "R2 window with no matching even position", 1, 0);
      return;
    end
    for (int ph = 0; ph < 4; ph++) begin
      int rp = ph & 1;
      int cp = (ph >> 1) & 1;
      logic [SUBN*W-1:0] bus = bus_of(ph);
      bit ok = 1, neg = 0;
      int act = 0, exp = 0;
      for (int a = 0; a < HL; a++) begin
        for (int b = 0; b < HM; b++) begin
          int r = 2 * q_m[qh] - 2 * a - rp;
          int c = 2 * q_n[qh] - 2 * b - cp;
          int e = pix(q_pat[qh], r, c);
          int g = int'(bus[(a*HM+b)*W +: W]);
          if (r < 0 || c < 0) neg = 1;
          if (g != e && ok) begin ok = 0; act = g; exp = e; end
        end
      end
      if (neg)     chk(ok, "R5 outside-frame samples read zero", act, exp);
      else if (cp) chk(ok, "R4 odd-column subwindow contents", act, exp);
      else         chk(ok, "R3 even-column subwindow contents", act, exp);
    end
    qh++;
    seen++;
  endtask

  task automatic run(int pat, int len, bit sof, bit gaps, bit bp, string tag);
    int idx = 0, exp_cnt = 0, guard = 0;
    bit stall_prev = 0;
    logic [4*SUBN*W-1:0] held = '0;
    seen = 0;
    for (int i = 0; i < len; i++)
      if ((i / N) % 2 == 0 && (i % N) % 2 == 0) exp_cnt++;
    while ((idx < len || qh != qt || win_valid) && guard < 5000) begin
      int r, c;
      guard++;
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (stall_prev)
        chk(win_valid && ({win_ee, win_oe, win_eo, win_oo} == held),
            "R8 window held under back-pressure", int'(win_valid), 1);
      r = idx / N;
      c = idx % N;
      in_valid  = (idx < len) && !(gaps && lf[0]);
      in_data   = W'(pix(pat, r, c));
      in_sof    = sof && (idx == 0);
      win_ready = !(bp && lf[2]) || (idx >= len);
      #1;
      if (win_valid && !win_ready)
        chk(!in_ready, "R8 input stalled while window waits", int'(in_ready), 0);
      stall_prev = win_valid && !win_ready;
      held = {win_ee, win_oe, win_eo, win_oo};
      if (win_valid && win_ready) check_window();
      if (in_valid && in_ready) begin
        if (r % 2 == 0 && c % 2 == 0) begin
          q_pat[qt] = pat;
          q_m[qt]   = r / 2;
          q_n[qt]   = c / 2;
          qt++;
        end
        idx++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    chk(seen == exp_cnt, tag, seen, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!win_valid, "R1 win_valid low in reset", int'(win_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!win_valid && in_ready, "R1 idle after reset", int'(in_ready), 1);

    run(0, N*N, 1, 0, 0, "R2 window count for plain frame");
    run(1, N*N, 1, 1, 1, "R9 window count with input gaps and back-pressure");
    run(2, 20, 1, 0, 1, "R6 window count before restart");
    run(3, N*N, 1, 1, 0, "R6 window count after mid-frame restart");
    run(2, N*N, 1, 0, 0, "R2 window count for constant frame");
    run(1, N*N, 0, 0, 1, "R7 window count after wrap without sof");
    run(0, N*N, 0, 1, 1, "R7 second wrapped frame");

    @(negedge clk);
    #1;
    chk(!win_valid && in_ready, "R10 output empties after last window",
        int'(win_valid), 0);
    chk(qh == qt, "R2 no expected window left unseen", qt - qh, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule